// File: doc/BRIEF.md
# Exception Entry Vector Unit

This block runs at the moment a processor core takes an exception. In one cycle the core presents a take strobe along with the exception kind, the PC of the faulting instruction, a flag saying whether that instruction sits in a branch delay slot, the faulting data address, and the current status bits. These status bits are the exception level, the error level, the boot-vector select, the interrupt-vector select, the debug-mode flag, the exception base and the current address-space identifier.

On the next clock edge the block registers its results. These are the handler PC to fetch from, the saved return PCs, the 5-bit cause code, the branch-delay flag, and the updated exception-level, error-level and boot-vector bits. For memory faults it also loads the bad-address, page-table context and translation-entry high registers.

Three kinds of exception take separate paths. General exceptions go through the common vector. Error-class exceptions (non-maskable interrupt and soft reset) go to the fixed error vector. Debug exceptions go to the fixed debug vector. Kind encodings outside the defined set are ignored.

Top module: `exc_entry_unit`

## Requirements
- R1: `kind_i` encodes 0 interrupt, 1 modify, 2 load-refill, 3 load-invalid, 4 store-refill, 5 store-invalid, 6 address-error load, 7 address-error store, 8 instruction bus error, 9 data bus error, 10 syscall, 11 break, 12 reserved instruction, 13 coprocessor unusable, 14 overflow, 15 trap, 16 floating point, 17 watch, 18 machine check, 19 cache error, 20 NMI, 21 soft reset, 22 debug. For general kinds, `cause_o` becomes, in that order: 0,1,2,2,3,3,4,5,6,7,8,9,10,11,12,13,15,23,24,30.
- R2: The vector base is 0xBFC00200 when `bev_i` is 1. When `bev_i` is 0 it is `ebase_i` with bits [9:0] cleared.
- R3: General exceptions use offset 0x180. An interrupt with `iv_i`=1 uses offset 0x200 instead.
- R4: A load-refill or store-refill uses offset 0x000 when `exl_i` is 0, and offset 0x180 when `exl_i` is 1.
- R5: A cache error goes to base+0x100 when `bev_i` is 1, and to base+0x20000100 when `bev_i` is 0.
- R6: On a general exception with `exl_i`=0, `epc_o` takes the return PC. The return PC is `pc_i`, or `pc_i`−4 when `in_slot_i`=1. `bd_o` takes `in_slot_i`. With `exl_i`=1 both `epc_o` and `bd_o` keep their previous values. In both cases `exl_o` becomes 1.
- R7: NMI and soft reset set `erl_o` and `bev_o`, load `error_epc_o` with the return PC, and jump to 0xBFC00000. `exl_o` copies `exl_i`. `epc_o` and `cause_o` are left unchanged.
- R8: A debug exception, or an interrupt while `dbg_mode_i`=1, loads `depc_o` with the return PC and jumps to 0xBFC00480. `cause_o` and `epc_o` are left unchanged.
- R9: Kinds 1 to 7 are memory faults. They load `bad_vaddr_o` with `fault_addr_i` and set `context_o`[22:4] to address bits [31:13]. They set `entry_hi_o` to {address[31:13], 5'b0, `asid_i`}. All other kinds leave these three registers unchanged.
- R10: After reset `done_o`, `handler_pc_o`, the saved PCs, `cause_o`, `bd_o`, `exl_o` and the fault registers are 0, and `erl_o`=`bev_o`=1. All results appear on the clock edge that samples `take_i`=1, and `done_o` is high for exactly that one cycle.
- R11: A take with a kind code of 23 to 31 changes no output, and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | One-cycle take-exception strobe |
| kind_i | input | 5 | Exception kind code |
| pc_i | input | 32 | PC of the faulting instruction |
| in_slot_i | input | 1 | Faulting instruction is in a delay slot |
| fault_addr_i | input | 32 | Faulting virtual address |
| dbg_mode_i | input | 1 | Core is in debug mode |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-vector select bit |
| iv_i | input | 1 | Interrupt uses the special vector |
| ebase_i | input | 32 | Exception base |
| asid_i | input | 8 | Current address-space identifier |
| done_o | output | 1 | Results updated this cycle |
| handler_pc_o | output | 32 | Handler entry PC |
| epc_o | output | 32 | Saved return PC (general) |
| error_epc_o | output | 32 | Saved return PC (error class) |
| depc_o | output | 32 | Saved return PC (debug) |
| cause_o | output | 5 | Exception cause code |
| bd_o | output | 1 | Branch-delay flag |
| exl_o | output | 1 | Updated exception-level bit |
| erl_o | output | 1 | Updated error-level bit |
| bev_o | output | 1 | Updated boot-vector bit |
| bad_vaddr_o | output | 32 | Bad virtual address |
| context_o | output | 32 | Page-table context |
| entry_hi_o | output | 32 | Translation entry high |

## Verification
Every result is registered on the edge that samples the strobe, so a wrong offset, base or cause selection shows at `handler_pc_o` or `cause_o` one cycle after the take. A save-enable error shows the same way: the exception-level gate on `epc_o`/`bd_o` or a path-group mix-up leaves a saved PC that differs from the expected one, or changes it when it should hold. A capture-enable error is only visible through the fault registers after a non-fault exception. For that reason, each non-fault scenario is checked against the values left by an earlier fault.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam logic [4:0] K_INT      = 5'd0;
   localparam logic [4:0] K_MOD      = 5'd1;
   localparam logic [4:0] K_LD_MISS  = 5'd2;
   localparam logic [4:0] K_LD_INV   = 5'd3;
   localparam logic [4:0] K_ST_MISS  = 5'd4;
   localparam logic [4:0] K_ST_INV   = 5'd5;
   localparam logic [4:0] K_ADR_LD   = 5'd6;
   localparam logic [4:0] K_ADR_ST   = 5'd7;
   localparam logic [4:0] K_IBUS     = 5'd8;
   localparam logic [4:0] K_DBUS     = 5'd9;
   localparam logic [4:0] K_SYS      = 5'd10;
   localparam logic [4:0] K_BRK      = 5'd11;
   localparam logic [4:0] K_RSV      = 5'd12;
   localparam logic [4:0] K_COP      = 5'd13;
   localparam logic [4:0] K_OVF      = 5'd14;
   localparam logic [4:0] K_TRAP     = 5'd15;
   localparam logic [4:0] K_FPU      = 5'd16;
   localparam logic [4:0] K_WATCH    = 5'd17;
   localparam logic [4:0] K_MCHK     = 5'd18;
   localparam logic [4:0] K_CACHE    = 5'd19;
   localparam logic [4:0] K_NMI      = 5'd20;
   localparam logic [4:0] K_SRST     = 5'd21;
   localparam logic [4:0] K_DEBUG    = 5'd22;

   typedef enum logic [1:0] {
      GRP_NONE    = 2'd0,
      GRP_GENERAL = 2'd1,
      GRP_ERROR   = 2'd2,
      GRP_DEBUG   = 2'd3
   } exc_group_e;

   typedef struct packed {
      exc_group_e grp;
      logic [4:0] cause;
      logic       refill;
      logic       mem_fault;
      logic       is_int;
      logic       is_cache;
   } exc_class_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_entry_pkg::*;
(
   input  logic [4:0] kind_i,
   input  logic       dbg_mode_i,
   output exc_class_t cls_o
);

   always_comb begin
      cls_o           = '0;
      cls_o.grp       = GRP_GENERAL;
      unique case (kind_i)
         K_INT:     begin
                       cls_o.cause  = 5'd0;
                       cls_o.is_int = 1'b1;
                       if (dbg_mode_i) cls_o.grp = GRP_DEBUG;
                    end
         K_MOD:     begin cls_o.cause = 5'd1; cls_o.mem_fault = 1'b1; end
         K_LD_MISS: begin cls_o.cause = 5'd2; cls_o.mem_fault = 1'b1; cls_o.refill = 1'b1; end
         K_LD_INV:  begin cls_o.cause = 5'd2; cls_o.mem_fault = 1'b1; end
         K_ST_MISS: begin cls_o.cause = 5'd3; cls_o.mem_fault = 1'b1; cls_o.refill = 1'b1; end
         K_ST_INV:  begin cls_o.cause = 5'd3; cls_o.mem_fault = 1'b1; end
         K_ADR_LD:  begin cls_o.cause = 5'd4; cls_o.mem_fault = 1'b1; end
         K_ADR_ST:  begin cls_o.cause = 5'd5; cls_o.mem_fault = 1'b1; end
         K_IBUS:    cls_o.cause = 5'd6;
         K_DBUS:    cls_o.cause = 5'd7;
         K_SYS:     cls_o.cause = 5'd8;
         K_BRK:     cls_o.cause = 5'd9;
         K_RSV:     cls_o.cause = 5'd10;
         K_COP:     cls_o.cause = 5'd11;
         K_OVF:     cls_o.cause = 5'd12;
         K_TRAP:    cls_o.cause = 5'd13;
         K_FPU:     cls_o.cause = 5'd15;
         K_WATCH:   cls_o.cause = 5'd23;
         K_MCHK:    cls_o.cause = 5'd24;
         K_CACHE:   begin cls_o.cause = 5'd30; cls_o.is_cache = 1'b1; end
         K_NMI,
         K_SRST:    cls_o.grp = GRP_ERROR;
         K_DEBUG:   cls_o.grp = GRP_DEBUG;
         default:   cls_o.grp = GRP_NONE;
      endcase
   end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_entry_pkg::*;
#(
   parameter int          ADDR_W         = 32,
   parameter int          EBASE_ALIGN    = 10,
   parameter logic [31:0] BOOT_BASE      = 32'hBFC0_0200,
   parameter logic [31:0] ERR_VEC        = 32'hBFC0_0000,
   parameter logic [31:0] DBG_VEC        = 32'hBFC0_0480,
   parameter logic [31:0] OFS_GENERAL    = 32'h0000_0180,
   parameter logic [31:0] OFS_INT_SPEC   = 32'h0000_0200,
   parameter logic [31:0] OFS_REFILL     = 32'h0000_0000,
   parameter logic [31:0] OFS_CACHE_BOOT = 32'h0000_0100,
   parameter logic [31:0] OFS_CACHE_NORM = 32'h2000_0100
) (
   input  exc_class_t        cls_i,
   input  logic              bev_i,
   input  logic              exl_i,
   input  logic              iv_i,
   input  logic [ADDR_W-1:0] ebase_i,
   output logic [ADDR_W-1:0] handler_o
);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] ebase_aligned;

   generate
      if (EBASE_ALIGN == 0) begin : g_no_align
         assign ebase_aligned = ebase_i;
      end else begin : g_align
         assign ebase_aligned = {ebase_i[ADDR_W-1:EBASE_ALIGN], {EBASE_ALIGN{1'b0}}};
      end
   endgenerate

   always_comb begin
      base = bev_i ? BOOT_BASE[ADDR_W-1:0] : ebase_aligned;
      if (cls_i.is_cache)
         offset = bev_i ? OFS_CACHE_BOOT[ADDR_W-1:0] : OFS_CACHE_NORM[ADDR_W-1:0];
      else if (cls_i.is_int && iv_i)
         offset = OFS_INT_SPEC[ADDR_W-1:0];
      else if (cls_i.refill && !exl_i)
         offset = OFS_REFILL[ADDR_W-1:0];
      else
         offset = OFS_GENERAL[ADDR_W-1:0];
   end

   always_comb begin
      unique case (cls_i.grp)
         GRP_ERROR: handler_o = ERR_VEC[ADDR_W-1:0];
         GRP_DEBUG: handler_o = DBG_VEC[ADDR_W-1:0];
         default:   handler_o = base + offset;
      endcase
   end

endmodule

// File: rtl/exc_fault_capture.sv
module exc_fault_capture #(
   parameter int ADDR_W  = 32,
   parameter int ASID_W  = 8,
   parameter int VPN_LSB = 13,
   parameter int CTX_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ASID_W-1:0] asid_i,
   output logic [ADDR_W-1:0] bad_vaddr_o,
   output logic [ADDR_W-1:0] context_o,
   output logic [ADDR_W-1:0] entry_hi_o
);

   localparam int VPN_W   = ADDR_W - VPN_LSB;
   localparam int CTX_MSB = CTX_LSB + VPN_W - 1;
   localparam int GAP_W   = VPN_LSB - ASID_W;

   logic [VPN_W-1:0] vpn2;
   assign vpn2 = addr_i[ADDR_W-1:VPN_LSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_vaddr_o <= '0;
         context_o   <= '0;
         entry_hi_o  <= '0;
      end else if (capture_i) begin
         bad_vaddr_o                 <= addr_i;
         context_o[CTX_MSB:CTX_LSB]  <= vpn2;
         entry_hi_o                  <= {vpn2, {GAP_W{1'b0}}, asid_i};
      end
   end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ASID_W      = 8,
   parameter int SLOT_BYTES  = 4,
   parameter int EBASE_ALIGN = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [4:0]        kind_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              in_slot_i,
   input  logic [ADDR_W-1:0] fault_addr_i,
   input  logic              dbg_mode_i,
   input  logic              exl_i,
   input  logic              erl_i,
   input  logic              bev_i,
   input  logic              iv_i,
   input  logic [ADDR_W-1:0] ebase_i,
   input  logic [ASID_W-1:0] asid_i,
   output logic              done_o,
   output logic [ADDR_W-1:0] handler_pc_o,
   output logic [ADDR_W-1:0] epc_o,
   output logic [ADDR_W-1:0] error_epc_o,
   output logic [ADDR_W-1:0] depc_o,
   output logic [4:0]        cause_o,
   output logic              bd_o,
   output logic              exl_o,
   output logic              erl_o,
   output logic              bev_o,
   output logic [ADDR_W-1:0] bad_vaddr_o,
   output logic [ADDR_W-1:0] context_o,
   output logic [ADDR_W-1:0] entry_hi_o
);

   localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(SLOT_BYTES);

   generate
      if (ADDR_W != 32) begin : g_bad_addr_w
         $error("exc_entry_unit: fixed vectors need ADDR_W == 32");
      end
      if (ASID_W > 13) begin : g_bad_asid_w
         $error("exc_entry_unit: ASID_W must fit below the page-pair field");
      end
      if (EBASE_ALIGN < 0 || EBASE_ALIGN > 16) begin : g_bad_align
         $error("exc_entry_unit: EBASE_ALIGN out of range");
      end
   endgenerate

   exc_class_t        cls;
   logic [ADDR_W-1:0] handler_next;
   logic [ADDR_W-1:0] resume_pc;
   logic              is_general;
   logic              is_error;
   logic              is_debug;
   logic              accepted;

   exc_classify u_classify (
      .kind_i     (kind_i),
      .dbg_mode_i (dbg_mode_i),
      .cls_o      (cls)
   );

   exc_vector_sel #(
      .ADDR_W      (ADDR_W),
      .EBASE_ALIGN (EBASE_ALIGN)
   ) u_vector (
      .cls_i     (cls),
      .bev_i     (bev_i),
      .exl_i     (exl_i),
      .iv_i      (iv_i),
      .ebase_i   (ebase_i),
      .handler_o (handler_next)
   );

   exc_fault_capture #(
      .ADDR_W (ADDR_W),
      .ASID_W (ASID_W)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (take_i && cls.mem_fault && cls.grp == GRP_GENERAL),
      .addr_i      (fault_addr_i),
      .asid_i      (asid_i),
      .bad_vaddr_o (bad_vaddr_o),
      .context_o   (context_o),
      .entry_hi_o  (entry_hi_o)
   );

   assign resume_pc  = in_slot_i ? (pc_i - SLOT_STEP) : pc_i;
   assign is_general = take_i && cls.grp == GRP_GENERAL;
   assign is_error   = take_i && cls.grp == GRP_ERROR;
   assign is_debug   = take_i && cls.grp == GRP_DEBUG;
   assign accepted   = is_general || is_error || is_debug;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o       <= 1'b0;
         handler_pc_o <= '0;
         epc_o        <= '0;
         error_epc_o  <= '0;
         depc_o       <= '0;
         cause_o      <= '0;
         bd_o         <= 1'b0;
         exl_o        <= 1'b0;
         erl_o        <= 1'b1;
         bev_o        <= 1'b1;
      end else begin
         done_o <= accepted;
         if (accepted) begin
            handler_pc_o <= handler_next;
            exl_o        <= exl_i;
            erl_o        <= erl_i;
            bev_o        <= bev_i;
         end
         if (is_general) begin
            cause_o <= cls.cause;
            exl_o   <= 1'b1;
            if (!exl_i) begin
               epc_o <= resume_pc;
               bd_o  <= in_slot_i;
            end
         end
         if (is_error) begin
            error_epc_o <= resume_pc;
            erl_o       <= 1'b1;
            bev_o       <= 1'b1;
         end
         if (is_debug) begin
            depc_o <= resume_pc;
         end
      end
   end

   // R6: saved PC and delay flag hold while already at exception level
   assert_epc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && exl_i && cls.grp == GRP_GENERAL) |=> ($stable(epc_o) && $stable(bd_o)));

   assert_exl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls.grp == GRP_GENERAL) |=> exl_o);

   assert_err_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls.grp == GRP_ERROR) |=> (erl_o && bev_o && $stable(epc_o) && $stable(cause_o)));

   assert_debug_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls.grp == GRP_DEBUG) |=> ($stable(epc_o) && $stable(cause_o)));

   assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(take_i && cls.mem_fault)) |=> ($stable(bad_vaddr_o) && $stable(entry_hi_o)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls.grp != GRP_NONE) |=> done_o);

   assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && cls.grp == GRP_NONE) |=> (!done_o && $stable(handler_pc_o)));

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [4:0]  kind_i = '0;
   logic [31:0] pc_i = '0;
   logic        in_slot_i = 1'b0;
   logic [31:0] fault_addr_i = '0;
   logic        dbg_mode_i = 1'b0;
   logic        exl_i = 1'b0;
   logic        erl_i = 1'b0;
   logic        bev_i = 1'b0;
   logic        iv_i = 1'b0;
   logic [31:0] ebase_i = 32'h8000_0000;
   logic [7:0]  asid_i = '0;
   logic        done_o;
   logic [31:0] handler_pc_o, epc_o, error_epc_o, depc_o;
   logic [4:0]  cause_o;
   logic        bd_o, exl_o, erl_o, bev_o;
   logic [31:0] bad_vaddr_o, context_o, entry_hi_o;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   exc_entry_unit u_exc_entry_unit (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .kind_i(kind_i), .pc_i(pc_i),
      .in_slot_i(in_slot_i), .fault_addr_i(fault_addr_i), .dbg_mode_i(dbg_mode_i),
      .exl_i(exl_i), .erl_i(erl_i), .bev_i(bev_i), .iv_i(iv_i), .ebase_i(ebase_i),
      .asid_i(asid_i), .done_o(done_o), .handler_pc_o(handler_pc_o), .epc_o(epc_o),
      .error_epc_o(error_epc_o), .depc_o(depc_o), .cause_o(cause_o), .bd_o(bd_o),
      .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o), .bad_vaddr_o(bad_vaddr_o),
      .context_o(context_o), .entry_hi_o(entry_hi_o)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", what, act, exp);
      end
   endtask

   // drive one take strobe, leave results visible at the following negedge
   task automatic fire(input logic [4:0] k, input logic [31:0] pc, input logic slot,
                       input logic [31:0] addr);
      @(negedge clk);
      kind_i = k; pc_i = pc; in_slot_i = slot; fault_addr_i = addr; take_i = 1'b1;
      @(negedge clk);
      take_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10 done after reset", {31'b0, done_o}, 32'd0);
      chk("R10 handler after reset", handler_pc_o, 32'd0);
      chk("R10 epc after reset", epc_o, 32'd0);
      chk("R10 erl/bev/exl after reset", {29'b0, erl_o, bev_o, exl_o}, 32'd6);
      chk("R10 bad_vaddr after reset", bad_vaddr_o, 32'd0);
   endtask

   task automatic t_general_boot;
      bev_i = 1; exl_i = 0; erl_i = 0;
      fire(5'd10, 32'h0000_1000, 1'b0, 32'h0);
      chk("R2 boot base syscall handler", handler_pc_o, 32'hBFC0_0380);
      chk("R1 syscall cause", {27'b0, cause_o}, 32'd8);
      chk("R6 epc plain", epc_o, 32'h0000_1000);
      chk("R6 bd clear", {31'b0, bd_o}, 32'd0);
      chk("R6 exl set", {31'b0, exl_o}, 32'd1);
      chk("R10 done pulse", {31'b0, done_o}, 32'd1);
      @(negedge clk);
      chk("R10 done one cycle", {31'b0, done_o}, 32'd0);
   endtask

   task automatic t_ebase;
      bev_i = 0; ebase_i = 32'h8000_1234;
      fire(5'd14, 32'h0000_2000, 1'b0, 32'h0);
      chk("R2 ebase aligned overflow handler", handler_pc_o, 32'h8000_1180);
      chk("R1 overflow cause", {27'b0, cause_o}, 32'd12);
      chk("R2 bev out copies input", {31'b0, bev_o}, 32'd0);
      fire(5'd16, 32'h0000_2010, 1'b0, 32'h0);
      chk("R1 fp cause", {27'b0, cause_o}, 32'd15);
      fire(5'd17, 32'h0000_2010, 1'b0, 32'h0);
      chk("R1 watch cause", {27'b0, cause_o}, 32'd23);
      fire(5'd18, 32'h0000_2010, 1'b0, 32'h0);
      chk("R1 machine check cause", {27'b0, cause_o}, 32'd24);
   endtask

   task automatic t_delay_slot;
      exl_i = 0;
      fire(5'd11, 32'h0000_3004, 1'b1, 32'h0);
      chk("R6 epc rewound", epc_o, 32'h0000_3000);
      chk("R6 bd set", {31'b0, bd_o}, 32'd1);
      chk("R1 break cause", {27'b0, cause_o}, 32'd9);
   endtask

   task automatic t_nested;
      exl_i = 1;
      fire(5'd15, 32'h0000_4444, 1'b0, 32'h0);
      chk("R6 epc held while exl", epc_o, 32'h0000_3000);
      chk("R6 bd held while exl", {31'b0, bd_o}, 32'd1);
      chk("R1 trap cause", {27'b0, cause_o}, 32'd13);
      chk("R6 exl stays set", {31'b0, exl_o}, 32'd1);
      exl_i = 0;
   endtask

   task automatic t_interrupt;
      bev_i = 0; ebase_i = 32'h8000_0000; iv_i = 1;
      fire(5'd0, 32'h0000_5000, 1'b0, 32'h0);
      chk("R3 special interrupt offset", handler_pc_o, 32'h8000_0200);
      chk("R1 interrupt cause", {27'b0, cause_o}, 32'd0);
      iv_i = 0;
      fire(5'd0, 32'h0000_5000, 1'b0, 32'h0);
      chk("R3 plain interrupt offset", handler_pc_o, 32'h8000_0180);
   endtask

   task automatic t_refill;
      bev_i = 0; ebase_i = 32'h8000_0000; asid_i = 8'h5A; exl_i = 0;
      fire(5'd2, 32'h0000_6000, 1'b0, 32'h1234_5678);
      chk("R4 load refill offset zero", handler_pc_o, 32'h8000_0000);
      chk("R1 load refill cause", {27'b0, cause_o}, 32'd2);
      chk("R9 bad vaddr", bad_vaddr_o, 32'h1234_5678);
      chk("R9 context page field", context_o, (32'h1234_5678 >> 13) << 4);
      chk("R9 entry hi", entry_hi_o, (32'h1234_5678 & 32'hFFFF_E000) | 32'h5A);
      exl_i = 1;
      fire(5'd4, 32'h0000_6004, 1'b0, 32'h0000_E000);
      chk("R4 store refill under exl", handler_pc_o, 32'h8000_0180);
      chk("R1 store refill cause", {27'b0, cause_o}, 32'd3);
      exl_i = 0;
      fire(5'd5, 32'h0000_6008, 1'b0, 32'hFFFF_FFFF);
      chk("R4 store invalid not refill", handler_pc_o, 32'h8000_0180);
      chk("R9 context all ones field", context_o, 32'h007F_FFF0);
      fire(5'd7, 32'h0000_6008, 1'b0, 32'hABCD_0123);
      chk("R1 address error store cause", {27'b0, cause_o}, 32'd5);
      chk("R9 entry hi adr store", entry_hi_o, 32'hABCD_005A);
      fire(5'd10, 32'h0000_6010, 1'b0, 32'h5555_5555);
      chk("R9 non-fault keeps bad vaddr", bad_vaddr_o, 32'hABCD_0123);
      chk("R9 non-fault keeps entry hi", entry_hi_o, 32'hABCD_005A);
   endtask

   task automatic t_cache;
      bev_i = 1;
      fire(5'd19, 32'h0000_7000, 1'b0, 32'h0);
      chk("R5 cache error boot", handler_pc_o, 32'hBFC0_0300);
      chk("R1 cache cause", {27'b0, cause_o}, 32'd30);
      bev_i = 0; ebase_i = 32'h8000_0000;
      fire(5'd19, 32'h0000_7000, 1'b0, 32'h0);
      chk("R5 cache error normal", handler_pc_o, 32'hA000_0100);
   endtask

   task automatic t_error_class;
      logic [31:0] epc_before;
      logic [4:0]  cause_before;
      epc_before = epc_o; cause_before = cause_o;
      bev_i = 0; erl_i = 0; exl_i = 0;
      fire(5'd20, 32'h0000_8008, 1'b1, 32'h0);
      chk("R7 nmi handler", handler_pc_o, 32'hBFC0_0000);
      chk("R7 error epc rewound", error_epc_o, 32'h0000_8004);
      chk("R7 erl bev set exl copied", {29'b0, erl_o, bev_o, exl_o}, 32'd6);
      chk("R7 epc unchanged", epc_o, epc_before);
      chk("R7 cause unchanged", {27'b0, cause_o}, {27'b0, cause_before});
      exl_i = 1;
      fire(5'd21, 32'h0000_9000, 1'b0, 32'h0);
      chk("R7 soft reset error epc", error_epc_o, 32'h0000_9000);
      chk("R7 soft reset exl copied", {31'b0, exl_o}, 32'd1);
      exl_i = 0;
   endtask

   task automatic t_debug;
      logic [31:0] epc_before;
      logic [4:0]  cause_before;
      epc_before = epc_o; cause_before = cause_o;
      fire(5'd22, 32'h0000_A004, 1'b1, 32'h0);
      chk("R8 debug handler", handler_pc_o, 32'hBFC0_0480);
      chk("R8 depc rewound", depc_o, 32'h0000_A000);
      chk("R8 epc unchanged", epc_o, epc_before);
      dbg_mode_i = 1;
      fire(5'd0, 32'h0000_B000, 1'b0, 32'h0);
      chk("R8 interrupt in debug mode", handler_pc_o, 32'hBFC0_0480);
      chk("R8 depc from interrupt", depc_o, 32'h0000_B000);
      chk("R8 cause unchanged", {27'b0, cause_o}, {27'b0, cause_before});
      dbg_mode_i = 0;
   endtask

   task automatic t_undefined;
      logic [31:0] h_before, e_before;
      h_before = handler_pc_o; e_before = epc_o;
      fire(5'd25, 32'h0000_C000, 1'b0, 32'h0);
      chk("R11 no done", {31'b0, done_o}, 32'd0);
      chk("R11 handler held", handler_pc_o, h_before);
      chk("R11 epc held", epc_o, e_before);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_general_boot();
      t_ebase();
      t_delay_slot();
      t_nested();
      t_interrupt();
      t_refill();
      t_cache();
      t_error_class();
      t_debug();
      t_undefined();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule